// File: doc/BRIEF.md
# Infrared Serial Receive Pulse Stretcher

This block turns the short return-to-zero pulses that an infrared receiver delivers into the non-return-to-zero level that a UART receive line expects. The receiver marks every zero bit with a brief low pulse on `irInN`. The block qualifies each such pulse and then holds `nrzOut` low for exactly one programmed bit period. The output width therefore depends only on `bitPeriod`, which is given in clock cycles. It does not depend on how long the incoming pulse lasted.

Consecutive zero bits merge into one continuous low level. A qualified pulse that arrives while a stretch is still running restarts the bit-period count. Pulses that are too short are treated as noise and dropped; this covers glitches on the optical front end. A gate can suppress the receiver's echo of the block's own transmission: while `echoGateEn` and `txBusy` are both high, the input is ignored. An active-low indicator output follows the stretched level so that it can drive an activity lamp.

Top module: `irPulseStretcher`

## Requirements
- R1: While `rstN` is low, and after its release until the first qualified pulse, `nrzOut` and `rxLedN` are both high.
- R2: `irInN` passes through a two-flop synchronizer. If it is sampled low at four consecutive rising edges k, k+1, k+2 and k+3, with a high sample at edge k-1, then `nrzOut` goes low after edge k+5.
- R3: Once lowered by a single qualified pulse, `nrzOut` stays low for exactly `bitPeriod` clock cycles and then returns high.
- R4: An input pulse that stays low for any number of edges beyond four produces one stretch of exactly `bitPeriod` cycles, the same as a four-edge pulse.
- R5: An input low level that is sampled at three or fewer consecutive edges leaves `nrzOut` high.
- R6: A qualified pulse whose stretch would begin while an earlier stretch is still running restarts the count. `nrzOut` then stays low without a gap until `bitPeriod` cycles after the new start.
- R7: While `echoGateEn` and `txBusy` are both 1, low samples on `irInN` are ignored and `nrzOut` stays high.
- R8: While `echoGateEn` is 0, `txBusy` has no effect on the output.
- R9: `rxLedN` is low in exactly the cycles in which `nrzOut` is low.
- R10: A `bitPeriod` of 0 suppresses the stretch, so `nrzOut` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing counts its rising edges |
| rstN | input | 1 | Asynchronous reset, active low |
| irInN | input | 1 | Infrared receiver data, low during a pulse |
| bitPeriod | input | CNT_W | One bit period in clock cycles |
| echoGateEn | input | 1 | 1 enables echo suppression during transmit |
| txBusy | input | 1 | High while the local transmitter is sending |
| nrzOut | output | 1 | Stretched NRZ receive data, idles high |
| rxLedN | output | 1 | Receive activity indicator, active low |

## Verification
The embedded properties check several rules on every cycle:
- the indicator always equals the data output;
- a stretch starts only after a qualified start strobe;
- the output rises only when the count expires;
- a held-low input yields a single start strobe;
- no start occurs while the echo gate blocks the input.

Some behaviour spans many cycles and only the bench scenarios can show it:
- the exact five-edge latency from qualification to output;
- the exact stretch width for various periods;
- the seamless merging of retriggered stretches;
- the rejection of three-edge glitches.

// File: rtl/irStretchPkg.sv
package irStretchPkg;

  // Strobes issued by the control to the stretch datapath.
  typedef struct packed {
    logic load;  // start a new bit-period stretch
    logic dec;   // count one cycle of a running stretch
  } stretchCtl_t;

endpackage

// File: rtl/irStretchDatapath.sv
module irStretchDatapath
  import irStretchPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irInN,
  input  logic             echoGateEn,
  input  logic             txBusy,
  input  logic [CNT_W-1:0] bitPeriod,
  input  stretchCtl_t      ctl,
  output logic             gatedLow,
  output logic             cntZero,
  output logic             nrzOut,
  output logic             rxLedN
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   irSync;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       cntNext;
  logic                   nrzReg;
  logic                   ledReg;

  // input synchronizer; the chain length is picked by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], irInN};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= irInN;
      end
    end
  endgenerate

  assign irSync   = syncQ[SYNC_STAGES-1];
  assign gatedLow = !irSync && !(echoGateEn && txBusy);
  assign cntZero  = (cnt == '0);

  always_comb begin
    cntNext = cnt;
    if (ctl.load)     cntNext = bitPeriod;
    else if (ctl.dec) cntNext = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      nrzReg <= 1'b1;
      ledReg <= 1'b1;
    end else begin
      cnt    <= cntNext;
      nrzReg <= (cntNext == '0);
      ledReg <= (cntNext == '0);
    end
  end

  assign nrzOut = nrzReg;
  assign rxLedN = ledReg;

  // R9
  led_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxLedN == nrzOut);

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nrzOut) |-> $past(ctl.load));

  // R3
  end_expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nrzOut) |-> (($past(cnt) == CNT_W'(1)) || $past(ctl.load)));

endmodule

// File: rtl/irStretchControl.sv
module irStretchControl
  import irStretchPkg::*;
#(
  parameter int GLITCH_MIN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        gatedLow,
  input  logic        cntZero,
  output stretchCtl_t ctl
);

  localparam int RUN_W = $clog2(GLITCH_MIN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GLITCH_MIN - 1);
  localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(GLITCH_MIN);

  logic [RUN_W-1:0] runCnt;

  // length of the current low run, saturating once qualified
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              runCnt <= '0;
    else if (!gatedLow)     runCnt <= '0;
    else if (runCnt != RUN_SAT) runCnt <= runCnt + 1'b1;
  end

  always_comb begin
    ctl.load = gatedLow && (runCnt == RUN_LAST);
    ctl.dec  = !cntZero && !ctl.load;
  end

  // R4
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.load) && gatedLow) |-> !ctl.load);

  // R5
  qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (gatedLow && $past(gatedLow)));

endmodule

// File: rtl/irPulseStretcher.sv
module irPulseStretcher
  import irStretchPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int GLITCH_MIN  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irInN,
  input  logic [CNT_W-1:0] bitPeriod,
  input  logic             echoGateEn,
  input  logic             txBusy,
  output logic             nrzOut,
  output logic             rxLedN
);

  stretchCtl_t ctlBus;
  logic        gatedLow;
  logic        cntZero;

  irStretchDatapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .irInN     (irInN),
    .echoGateEn(echoGateEn),
    .txBusy    (txBusy),
    .bitPeriod (bitPeriod),
    .ctl       (ctlBus),
    .gatedLow  (gatedLow),
    .cntZero   (cntZero),
    .nrzOut    (nrzOut),
    .rxLedN    (rxLedN)
  );

  irStretchControl #(
    .GLITCH_MIN(GLITCH_MIN)
  ) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .gatedLow(gatedLow),
    .cntZero (cntZero),
    .ctl     (ctlBus)
  );

  // R7
  echo_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (echoGateEn && txBusy) |-> !ctlBus.load);

endmodule

// File: tb/test_irPulseStretcher.sv
module test_irPulseStretcher;

  localparam int GLITCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irInN = 1'b1;
  logic [15:0] bitPeriod = 16'd20;
  logic        echoGateEn = 1'b0;
  logic        txBusy = 1'b0;
  logic        nrzOut;
  logic        rxLedN;

  int total = 0;
  int bad = 0;
  int edgeN = 0;
  int runLen = 0;
  int pendLoad = -100;
  int deadline = 0;
  int lowSeen = 0;
  int firstLow = -1;

  always #2 clk = ~clk;

  irPulseStretcher i_irPulseStretcher (
    .clk       (clk),
    .rstN      (rstN),
    .irInN     (irInN),
    .bitPeriod (bitPeriod),
    .echoGateEn(echoGateEn),
    .txBusy    (txBusy),
    .nrzOut    (nrzOut),
    .rxLedN    (rxLedN)
  );

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at edge %0d", tag, got, exp, edgeN);
    end
  endtask

  // one clock: drive, model the edge, check after it
  task automatic step(logic inLow, string tag);
    logic expLow;
    irInN = !inLow;
    @(posedge clk);
    edgeN++;
    if (pendLoad == edgeN) deadline = edgeN + int'(bitPeriod);
    if (inLow && !(echoGateEn && txBusy)) runLen++;
    else runLen = 0;
    if (runLen == GLITCH) pendLoad = edgeN + 2;
    expLow = (edgeN < deadline);
    @(negedge clk);
    check(tag, int'(nrzOut), int'(!expLow));
    check("R9", int'(rxLedN), int'(nrzOut));
    if (!nrzOut) begin
      lowSeen++;
      if (firstLow < 0) firstLow = edgeN;
    end
  endtask

  task automatic burst(int lowLen, int idle, string tag);
    lowSeen = 0;
    firstLow = -1;
    for (int i = 0; i < lowLen; i++) step(1'b1, tag);
    for (int i = 0; i < idle; i++) step(1'b0, tag);
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    void'($urandom(32'd4711));
    // R1 during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(nrzOut), 1);
    check("R1", int'(rxLedN), 1);
    rstN = 1'b1;
    edgeN = 0;
    burst(0, 8, "R1");
    check("R1", lowSeen, 0);

    // R2 and R3: minimal qualified pulse
    s = edgeN + 1;
    burst(4, 40, "R3");
    check("R3", lowSeen, 20);
    check("R2", firstLow, s + 5);

    // R5: three-edge glitch
    burst(3, 30, "R5");
    check("R5", lowSeen, 0);

    // R4: long pulse
    burst(50, 30, "R4");
    check("R4", lowSeen, 20);

    // R6: retrigger merges into one level
    s = edgeN + 1;
    lowSeen = 0;
    firstLow = -1;
    for (int i = 0; i < 4; i++) step(1'b1, "R6");
    for (int i = 0; i < 6; i++) step(1'b0, "R6");
    for (int i = 0; i < 4; i++) step(1'b1, "R6");
    for (int i = 0; i < 40; i++) step(1'b0, "R6");
    check("R6", lowSeen, 30);
    check("R6", firstLow, s + 5);

    // R7: echo gate blocks
    echoGateEn = 1'b1;
    txBusy = 1'b1;
    burst(10, 30, "R7");
    check("R7", lowSeen, 0);

    // R8: gate disabled, transmit flag has no effect
    echoGateEn = 1'b0;
    burst(10, 30, "R8");
    check("R8", lowSeen, 20);
    txBusy = 1'b0;

    // R10: zero period
    bitPeriod = 16'd0;
    burst(10, 20, "R10");
    check("R10", lowSeen, 0);

    // R3 boundary: one-cycle period
    bitPeriod = 16'd1;
    burst(4, 20, "R3");
    check("R3", lowSeen, 1);

    // random mix, settings change only when idle
    for (int it = 0; it < 200; it++) begin
      if ($urandom_range(0, 3) == 0 || it == 0) begin
        bitPeriod = 16'($urandom_range(1, 40));
        echoGateEn = 1'($urandom_range(0, 1));
        txBusy = 1'($urandom_range(0, 1));
      end
      for (int p = 0; p < int'($urandom_range(1, 4)); p++)
        burst(int'($urandom_range(1, 12)), int'($urandom_range(1, 25)), "R6");
      burst(0, 50, "R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule